// File: doc/BRIEF.md
# Paged Program Counter Target Unit

This block owns the 24-bit program counter of an 8051-style core that can reach past 64 KB. It takes one control-transfer request at a time: a sequential step, a long jump, an absolute call, a long call, an interrupt entry or a return from interrupt. From the request, the selected addressing mode and an 8-bit address page register it forms the next PC. Calls and interrupt entries stream the return address out as bytes for the stack. A return from interrupt streams the saved bytes back in.

The page register sits behind a small special-function register port. In paged mode it supplies the top byte of jump and call targets. It is never advanced by a 16-bit wrap of the PC, and it is never saved or restored by the block. A handler that changes it must save it itself.

Requests use a valid/ready handshake: `op_ready` is high only while no stack transfer is in progress. The push stream and the pop stream follow valid/ready rules. A pushed byte stays on `push_data` until it is taken. The unit waits without limit for `pop_valid`. With `push_ready` held high, each byte is a single-cycle strobe.

Top module: `pc_target_unit`

## Requirements
- R1: After reset the PC is 000000h, the page register reads 00h, `op_ready` is 1 and `push_valid` and `pop_ready` are 0.
- R2: The page register is written by `sfr_wr` when `sfr_addr` is 9Ch and reads back on `sfr_rdata` at that address; writes to any other address leave it unchanged, and reads there return 00h.
- R3: A sequential step (op code 0) adds one to the PC. In mode 00 (16-bit) the result has bits 23:16 at zero. In mode 01 (paged) the low 16 bits wrap from FFFFh to 0000h, and bits 23:16 and the page register stay unchanged. In modes 10 and 11 (contiguous) the carry runs through all 24 bits.
- R4: For a long jump (op code 1) or long call (op code 3), the target is built by mode. Mode 00 gives {00h, addr[15:0]}. Mode 01 gives {page, addr[15:0]}. Modes 1x give addr[23:0].
- R5: An absolute call (op code 2) forms its target as {upper, PC[15:11], addr[10:0]}. The upper byte is 00h in mode 00, the page register in mode 01, and PC[23:16] in modes 1x.
- R6: Interrupt entry (op code 4) targets {00h, addr[15:0]} in every mode.
- R7: Calls and interrupt entries push the current PC low byte first: three bytes in modes 01 and 1x, two bytes in mode 00. The page register is never pushed. The PC takes the target on the edge that accepts the last byte and is held until then.
- R8: While a byte waits on `push_valid` without `push_ready`, `push_data` stays stable. `op_ready` stays low for the whole stack transfer. The push and pop streams are never active together.
- R9: Return from interrupt (op code 5) pops the high byte first: three bytes in modes 01 and 1x, two in mode 00 with bits 23:16 then zero. It loads the whole PC from the popped bytes and leaves the page register as it was.
- R10: Outside mode 01 the page register has no effect on any target.
- R11: Op codes 6 and 7 are accepted and leave the PC unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Addressing mode: 00 16-bit, 01 paged, 1x contiguous |
| op_valid | input | 1 | Request present |
| op_ready | output | 1 | Unit can accept a request |
| op_code | input | 3 | 0 step, 1 long jump, 2 absolute call, 3 long call, 4 interrupt, 5 return |
| op_addr | input | 24 | Address operand of the request |
| pc | output | 24 | Current program counter |
| push_valid | output | 1 | A stack byte is offered |
| push_ready | input | 1 | Stack takes the offered byte |
| push_data | output | 8 | Byte to push |
| pop_valid | input | 1 | A popped byte is offered |
| pop_ready | output | 1 | Unit takes a popped byte |
| pop_data | input | 8 | Popped byte |
| sfr_addr | input | 8 | Special-function register address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data |

## Verification
On every cycle, the assertions check four things. The first is the stream rules: a held push byte stays stable, requests are blocked while busy, and the two streams are exclusive. The second is that the PC is frozen while a push stalls. The third is how a step treats the upper byte in 16-bit and paged modes. The fourth is that the page register only changes through its own write address. The concrete targets per mode, the byte order and byte count of pushes and pops, the wrap at FFFFh, and a return after the handler changed the page register all depend on specific values. Those only the bench's scenarios show, by comparing against values worked out by hand.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam logic [1:0] MODE_16    = 2'b00;
  localparam logic [1:0] MODE_PAGED = 2'b01;

  typedef enum logic [2:0] {
    OP_STEP  = 3'd0,
    OP_LJMP  = 3'd1,
    OP_ACALL = 3'd2,
    OP_LCALL = 3'd3,
    OP_INT   = 3'd4,
    OP_RETI  = 3'd5
  } op_e;

  function automatic logic is_contig(input logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/pct_page_reg.sv
module pct_page_reg #(
  parameter int          DW      = 8,
  parameter int          AW      = 8,
  parameter logic [7:0]  REG_ADR = 8'h9C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sfr_addr,
  input  logic          sfr_wr,
  input  logic [DW-1:0] sfr_wdata,
  output logic [DW-1:0] sfr_rdata,
  output logic [DW-1:0] page_q
);
  logic hit;
  assign hit = (sfr_addr == AW'(REG_ADR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             page_q <= '0;
    else if (sfr_wr && hit) page_q <= sfr_wdata;
  end

  assign sfr_rdata = hit ? page_q : '0;
endmodule

// File: rtl/pct_target.sv
module pct_target
  import pct_pkg::*;
#(
  parameter int PC_W   = 24,
  parameter int PAGE_W = 8
) (
  input  logic [1:0]        mode,
  input  logic [2:0]        op_code,
  input  logic [PC_W-1:0]   op_addr,
  input  logic [PC_W-1:0]   pc,
  input  logic [PAGE_W-1:0] page,
  output logic [PC_W-1:0]   target
);
  localparam int LOW_W = PC_W - PAGE_W;
  localparam int ABS_W = 11;

  logic [PAGE_W-1:0] long_up, abs_up;
  logic [LOW_W-1:0]  low_inc;

  always_comb begin
    if (is_contig(mode)) begin
      long_up = op_addr[PC_W-1:LOW_W];
      abs_up  = pc[PC_W-1:LOW_W];
    end else if (mode == MODE_PAGED) begin
      long_up = page;
      abs_up  = page;
    end else begin
      long_up = '0;
      abs_up  = '0;
    end
  end

  assign low_inc = pc[LOW_W-1:0] + LOW_W'(1);

  always_comb begin
    target = pc;
    case (op_code)
      OP_STEP: begin
        if (is_contig(mode))          target = pc + PC_W'(1);
        else if (mode == MODE_PAGED)  target = {pc[PC_W-1:LOW_W], low_inc};
        else                          target = {{PAGE_W{1'b0}}, low_inc};
      end
      OP_LJMP, OP_LCALL: target = {long_up, op_addr[LOW_W-1:0]};
      OP_ACALL:          target = {abs_up, pc[LOW_W-1:ABS_W], op_addr[ABS_W-1:0]};
      OP_INT:            target = {{PAGE_W{1'b0}}, op_addr[LOW_W-1:0]};
      default:           target = pc;
    endcase
  end
endmodule

// File: rtl/pct_stack_seq.sv
module pct_stack_seq #(
  parameter int PC_W = 24,
  parameter int BW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_call,
  input  logic            start_ret,
  input  logic            wide,
  input  logic [PC_W-1:0] ret_addr,
  input  logic [PC_W-1:0] call_tgt,
  output logic            push_valid,
  input  logic            push_ready,
  output logic [BW-1:0]   push_data,
  input  logic            pop_valid,
  output logic            pop_ready,
  input  logic [BW-1:0]   pop_data,
  output logic            busy,
  output logic            load_en,
  output logic [PC_W-1:0] load_val
);
  localparam int NB    = PC_W / BW;
  localparam int CNT_W = $clog2(NB + 1);

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_POP} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q, last_idx_q;
  logic [PC_W-1:0]  shift_q, tgt_q;
  logic             last, push_fire, pop_fire;

  assign last      = (cnt_q == last_idx_q);
  assign push_fire = (st_q == S_PUSH) && push_ready;
  assign pop_fire  = (st_q == S_POP) && pop_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      cnt_q      <= '0;
      last_idx_q <= '0;
      shift_q    <= '0;
      tgt_q      <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          cnt_q      <= '0;
          last_idx_q <= wide ? CNT_W'(NB - 1) : CNT_W'(NB - 2);
          if (start_call) begin
            st_q    <= S_PUSH;
            shift_q <= ret_addr;
            tgt_q   <= call_tgt;
          end else if (start_ret) begin
            st_q    <= S_POP;
            shift_q <= '0;
          end
        end
        S_PUSH: if (push_fire) begin
          shift_q <= shift_q >> BW;
          cnt_q   <= cnt_q + CNT_W'(1);
          if (last) st_q <= S_IDLE;
        end
        S_POP: if (pop_fire) begin
          shift_q <= {shift_q[PC_W-BW-1:0], pop_data};
          cnt_q   <= cnt_q + CNT_W'(1);
          if (last) st_q <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign push_valid = (st_q == S_PUSH);
  assign push_data  = shift_q[BW-1:0];
  assign pop_ready  = (st_q == S_POP);
  assign busy       = (st_q != S_IDLE);
  assign load_en    = (push_fire || pop_fire) && last;
  assign load_val   = push_fire ? tgt_q : {shift_q[PC_W-BW-1:0], pop_data};
endmodule

// File: rtl/pc_target_unit.sv
module pc_target_unit
  import pct_pkg::*;
#(
  parameter int         PC_W    = 24,
  parameter int         BW      = 8,
  parameter int         SFR_AW  = 8,
  parameter logic [7:0] PAGE_AD = 8'h9C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_code,
  input  logic [PC_W-1:0]   op_addr,
  output logic [PC_W-1:0]   pc,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [BW-1:0]     push_data,
  input  logic              pop_valid,
  output logic              pop_ready,
  input  logic [BW-1:0]     pop_data,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_wr,
  input  logic [BW-1:0]     sfr_wdata,
  output logic [BW-1:0]     sfr_rdata
);
  logic [BW-1:0]   page_q;
  logic [PC_W-1:0] pc_q, target, load_val;
  logic            accept, is_call, is_ret, busy, load_en;

  pct_page_reg #(.DW(BW), .AW(SFR_AW), .REG_ADR(PAGE_AD)) u_page (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .page_q(page_q)
  );

  pct_target #(.PC_W(PC_W), .PAGE_W(BW)) u_tgt (
    .mode(mode), .op_code(op_code), .op_addr(op_addr), .pc(pc_q),
    .page(page_q), .target(target)
  );

  assign op_ready = !busy;
  assign accept   = op_valid && op_ready;
  assign is_call  = (op_code == OP_ACALL) || (op_code == OP_LCALL) ||
                    (op_code == OP_INT);
  assign is_ret   = (op_code == OP_RETI);

  pct_stack_seq #(.PC_W(PC_W), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_call(accept && is_call), .start_ret(accept && is_ret),
    .wide(mode != MODE_16), .ret_addr(pc_q), .call_tgt(target),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
    .busy(busy), .load_en(load_en), .load_val(load_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pc_q <= '0;
    else if (load_en)
      pc_q <= load_val;
    else if (accept && (op_code == OP_STEP || op_code == OP_LJMP))
      pc_q <= target;
  end

  assign pc = pc_q;
endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
  parameter int         PC_W    = 24,
  parameter int         BW      = 8,
  parameter logic [7:0] PAGE_AD = 8'h9C
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      mode,
  input logic            op_valid,
  input logic            op_ready,
  input logic [2:0]      op_code,
  input logic [PC_W-1:0] pc,
  input logic            push_valid,
  input logic            push_ready,
  input logic [BW-1:0]   push_data,
  input logic            pop_ready,
  input logic [7:0]      sfr_addr,
  input logic            sfr_wr,
  input logic [BW-1:0]   sfr_wdata,
  input logic [BW-1:0]   page_q
);
  logic step_acc;
  assign step_acc = op_valid && op_ready && (op_code == 3'd0);

  assert_push_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> push_valid && $stable(push_data));
  assert_busy_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid || pop_ready |-> !op_ready);
  assert_stream_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_valid && pop_ready));
  assert_pc_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> $stable(pc));
  assert_step16_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_acc && mode == 2'b00 |=> pc[PC_W-1:PC_W-BW] == '0);
  assert_steppaged_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_acc && mode == 2'b01 |=> pc[PC_W-1:PC_W-BW] == $past(pc[PC_W-1:PC_W-BW]));
  assert_page_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_wr && sfr_addr == PAGE_AD |=> page_q == $past(sfr_wdata));
  assert_page_only_sfr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_wr && sfr_addr == PAGE_AD) |=> $stable(page_q));
endmodule

bind pc_target_unit pct_checker #(.PC_W(PC_W), .BW(BW), .PAGE_AD(PAGE_AD)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .op_valid(op_valid),
  .op_ready(op_ready), .op_code(op_code), .pc(pc), .push_valid(push_valid),
  .push_ready(push_ready), .push_data(push_data), .pop_ready(pop_ready),
  .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .page_q(page_q)
);

// File: tb/pc_target_unit_bench.sv
module pc_target_unit_bench;
  logic        clk = 0, rst_n = 0;
  logic [1:0]  mode = 0;
  logic        op_valid = 0, op_ready;
  logic [2:0]  op_code = 0;
  logic [23:0] op_addr = 0, pc;
  logic        push_valid, push_ready = 0, pop_valid = 0, pop_ready;
  logic [7:0]  push_data, pop_data = 0;
  logic [7:0]  sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
  logic        sfr_wr = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pc_target_unit u_pc_target_unit (.*);

  task automatic chk(string req, string what, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_page(logic [7:0] a, logic [7:0] d);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1;
    @(posedge clk); @(negedge clk);
    sfr_wr = 0;
  endtask

  task automatic rd_page(string req, logic [7:0] a, logic [7:0] exp);
    sfr_addr = a; #1;
    chk(req, "sfr read", {16'h0, sfr_rdata}, {16'h0, exp});
  endtask

  task automatic issue(logic [1:0] m, logic [2:0] c, logic [23:0] a);
    mode = m; op_code = c; op_addr = a; op_valid = 1;
    @(posedge clk); @(negedge clk);
    op_valid = 0;
  endtask

  task automatic take_push(string req, int n, logic [23:0] exp, bit stall);
    for (int i = 0; i < n; i++) begin
      chk(req, "push_valid", {23'h0, push_valid}, 24'h1);
      chk("R8", "op_ready busy", {23'h0, op_ready}, 24'h0);
      if (stall && i == 1) begin
        @(posedge clk); @(negedge clk);
        chk("R8", "held byte", {16'h0, push_data}, {16'h0, exp[8*i +: 8]});
      end
      chk(req, "push byte", {16'h0, push_data}, {16'h0, exp[8*i +: 8]});
      push_ready = 1;
      @(posedge clk); @(negedge clk);
      push_ready = 0;
    end
    chk(req, "push done", {23'h0, push_valid}, 24'h0);
  endtask

  task automatic give_pop(string req, int n, logic [23:0] bytes_hi_first);
    for (int i = n - 1; i >= 0; i--) begin
      chk(req, "pop_ready", {23'h0, pop_ready}, 24'h1);
      pop_valid = 1; pop_data = bytes_hi_first[8*i +: 8];
      @(posedge clk); @(negedge clk);
      pop_valid = 0;
    end
  endtask

  task automatic t_reset;
    chk("R1", "pc", pc, 24'h0);
    chk("R1", "op_ready", {23'h0, op_ready}, 24'h1);
    chk("R1", "push_valid", {23'h0, push_valid}, 24'h0);
    chk("R1", "pop_ready", {23'h0, pop_ready}, 24'h0);
    rd_page("R1", 8'h9C, 8'h00);
  endtask

  task automatic t_sfr;
    wr_page(8'h9C, 8'h5A);
    rd_page("R2", 8'h9C, 8'h5A);
    wr_page(8'h9D, 8'hFF);
    rd_page("R2", 8'h9C, 8'h5A);
    rd_page("R2", 8'h9D, 8'h00);
  endtask

  task automatic t_mode16;
    issue(2'b00, 3'd1, 24'h33FFFF);
    chk("R10", "16-bit ljmp ignores page", pc, 24'h00FFFF);
    issue(2'b00, 3'd0, 0);
    chk("R3", "16-bit wrap", pc, 24'h000000);
    issue(2'b00, 3'd1, 24'h001234);
    issue(2'b00, 3'd3, 24'h77ABCD);
    take_push("R7", 2, 24'h001234, 1'b1);
    chk("R4", "16-bit lcall target", pc, 24'h00ABCD);
    issue(2'b00, 3'd5, 0);
    give_pop("R9", 2, 24'h001234);
    chk("R9", "16-bit reti", pc, 24'h001234);
    issue(2'b00, 3'd6, 24'h999999);
    chk("R11", "unused op", pc, 24'h001234);
  endtask

  task automatic t_paged;
    wr_page(8'h9C, 8'h05);
    issue(2'b01, 3'd1, 24'hEEFFFF);
    chk("R4", "paged ljmp", pc, 24'h05FFFF);
    issue(2'b01, 3'd0, 0);
    chk("R3", "paged wrap keeps page", pc, 24'h050000);
    rd_page("R3", 8'h9C, 8'h05);
    wr_page(8'h9C, 8'h0A);
    issue(2'b01, 3'd2, 24'hFFF123);
    take_push("R7", 3, 24'h050000, 1'b0);
    chk("R5", "paged acall", pc, 24'h0A0123);
  endtask

  task automatic t_interrupt;
    wr_page(8'h9C, 8'h12);
    issue(2'b01, 3'd1, 24'h003456);
    chk("R4", "paged ljmp", pc, 24'h123456);
    issue(2'b01, 3'd4, 24'hAB0003);
    take_push("R7", 3, 24'h123456, 1'b1);
    chk("R6", "vector", pc, 24'h000003);
    wr_page(8'h9C, 8'h77);
    issue(2'b01, 3'd1, 24'h000100);
    chk("R4", "handler ljmp", pc, 24'h770100);
    issue(2'b01, 3'd5, 0);
    give_pop("R9", 3, 24'h123456);
    chk("R9", "paged reti", pc, 24'h123456);
    rd_page("R9", 8'h9C, 8'h77);
  endtask

  task automatic t_contig;
    wr_page(8'h9C, 8'h44);
    issue(2'b10, 3'd1, 24'h05FFFF);
    chk("R10", "contig ljmp", pc, 24'h05FFFF);
    issue(2'b11, 3'd0, 0);
    chk("R3", "contig carry", pc, 24'h060000);
    issue(2'b10, 3'd2, 24'h0007FF);
    take_push("R7", 3, 24'h060000, 1'b0);
    chk("R5", "contig acall", pc, 24'h0607FF);
    issue(2'b11, 3'd3, 24'h3210FE);
    take_push("R7", 3, 24'h0607FF, 1'b0);
    chk("R4", "contig lcall", pc, 24'h3210FE);
    issue(2'b10, 3'd4, 24'h99000B);
    take_push("R7", 3, 24'h3210FE, 1'b0);
    chk("R6", "contig vector", pc, 24'h00000B);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_sfr;
    t_mode16;
    t_paged;
    t_interrupt;
    t_contig;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule